// File: doc/BRIEF.md
# Prioritized DSP Exception Controller

This block decides, once per instruction, whether a small 16-bit DSP core must leave its normal flow and enter an exception handler. It keeps one pending flag per exception level. Other logic in the core raises levels 0 to 6 through a request vector. The top level is raised only by the external-interrupt condition. The core marks each instruction boundary with a strobe. At that strobe the block picks the lowest eligible pending level. It then issues, all in one cycle, a PC load to that level's vector, a push of the current PC onto the return-address stack, and a push of the status word onto the status stack. The level it serviced is cleared from its pending flags.

The stacks and the instruction decode sit outside the block. A return from a handler reaches the block as a request at a boundary, and the block turns it into a pop strobe on both stacks. The push and pop ports are plain strobes with no back-pressure, because the stacks must accept every transfer in the cycle it is issued. The status word, the external flag and the PC are plain control inputs, sampled at the clock edge.

Top module: `trap_unit`

## Requirements
- R1: After reset, pc_load, push_c_valid, push_d_valid, pop_c and pop_d are 0, new_pc is 0, and no level is pending, so a boundary with global enable on causes no entry.
- R2: On a boundary with eligible pending levels, the lowest-numbered eligible level is taken. In the next cycle pc_load is 1 for exactly one cycle and new_pc equals 2 x level.
- R3: In the same cycle as pc_load, push_c_valid and push_d_valid are both 1. push_c_data holds the cur_pc value and push_d_data holds the status_reg value, both sampled at the boundary.
- R4: The pending flag of the taken level is cleared, so the next boundary takes the next eligible level, and a level is never taken twice from one request.
- R5: Levels 0 to 6 are eligible only while status_reg bit 9 (global enable) is 1. Level 7 is eligible whatever that bit is.
- R6: Level 7 becomes pending only in a cycle where ext_flag is 1 and status_reg bit 11 (external enable) is 1. Either condition alone raises nothing.
- R7: Without a boundary strobe, or with no eligible pending level, the block asserts none of pc_load, push or pop, and pending levels stay pending.
- R8: A request for one level in the same cycle as the clear of another level is merged and kept. A request for the very level being cleared wins, and that level stays pending.
- R9: A boundary with ret_req set gives pop_c and pop_d for one cycle in the next cycle. No entry is taken at that boundary, and pending levels wait for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | Instruction boundary strobe; evaluation happens only here |
| set_req | input | 7 | Raise requests for levels 0 to 6, bit i raises level i |
| ext_flag | input | 1 | External-interrupt flag from the control register |
| status_reg | input | 16 | Status word; bit 9 global enable, bit 11 external enable |
| cur_pc | input | 16 | PC of the next instruction at the boundary |
| ret_req | input | 1 | Return-from-handler request, valid with insn_boundary |
| pc_load | output | 1 | One-cycle strobe to load new_pc into the PC |
| new_pc | output | 16 | Vector address of the entered level (2 x level) |
| push_c_valid | output | 1 | Push strobe for the return-address stack |
| push_c_data | output | 16 | Return PC to push |
| push_d_valid | output | 1 | Push strobe for the status stack |
| push_d_data | output | 16 | Status word to push |
| pop_c | output | 1 | Pop strobe for the return-address stack |
| pop_d | output | 1 | Pop strobe for the status stack |

## Verification
Two pairs of functions can fall in the same cycle. The first is a new raise request arriving at the edge where the taken level's flag is cleared. The second is a return request arriving at a boundary where an entry is also eligible. The bench provokes the first by driving set_req during the boundary cycle, once for a different level and once for the level being taken. It judges the outcome from the vectors that the following boundaries produce. It provokes the second by holding a pending level while a return arrives. It then expects pop strobes with no PC load, and the deferred entry at the next boundary.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int TRAP_LVLS    = 8;
  localparam int TRAP_PC_W    = 16;
  localparam int TRAP_SR_W    = 16;
  localparam int TRAP_GIE_BIT = 9;
  localparam int TRAP_XIE_BIT = 11;
endpackage

// File: rtl/trap_pending.sv
module trap_pending #(
  parameter int NUM_LVL = trap_pkg::TRAP_LVLS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-2:0] set_req,
  input  logic               ext_flag,
  input  logic               xie,
  input  logic [NUM_LVL-1:0] clr_mask,
  output logic [NUM_LVL-1:0] pend
);
  logic [NUM_LVL-1:0] set_all;

  // the top level has no direct request path: only the gated external flag
  assign set_all = {ext_flag & xie, set_req};

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | set_all;
  end

  // R4: a cleared level without a same-cycle request is gone next cycle
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_all)) |=> ((pend & $past(clr_mask & ~set_all)) == '0));

  // R8: a request on the level being cleared keeps it pending
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & set_all)) |=> ((pend & $past(clr_mask & set_all)) == $past(clr_mask & set_all)));

  // R8: at most one level is cleared per cycle
  p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_mask));

  // R6: the top level appears only after flag and enable together
  p_ext_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[NUM_LVL-1]) |-> $past(ext_flag && xie));
endmodule

// File: rtl/trap_pick.sv
module trap_pick #(
  parameter int NUM_LVL = trap_pkg::TRAP_LVLS,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] pend,
  input  logic               gie,
  output logic               take_valid,
  output logic [LVL_W-1:0]   take_lvl
);
  logic [NUM_LVL-1:0] elig;
  logic [NUM_LVL:0]   below;
  logic [NUM_LVL-1:0] hot;

  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_LVL; g++) begin : g_lvl
      if (g == NUM_LVL - 1) begin : g_top
        assign elig[g] = pend[g];
      end else begin : g_low
        assign elig[g] = pend[g] & gie;
      end
      assign hot[g]     = elig[g] & ~below[g];
      assign below[g+1] = below[g] | elig[g];
    end
  endgenerate

  assign take_valid = below[NUM_LVL];

  always_comb begin
    take_lvl = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (hot[i]) take_lvl = LVL_W'(i);
  end

  // R2: nothing eligible sits below the chosen level
  p_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> ((elig & ((NUM_LVL'(1) << take_lvl) - NUM_LVL'(1))) == '0));

  // R5: with global enable off only the top level is chosen
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !gie) |-> (take_lvl == LVL_W'(NUM_LVL - 1)));
endmodule

// File: rtl/trap_launch.sv
module trap_launch #(
  parameter int NUM_LVL = trap_pkg::TRAP_LVLS,
  parameter int PC_W    = trap_pkg::TRAP_PC_W,
  parameter int SR_W    = trap_pkg::TRAP_SR_W,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_boundary,
  input  logic               ret_req,
  input  logic               take_valid,
  input  logic [LVL_W-1:0]   take_lvl,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic [SR_W-1:0]    status_reg,
  output logic [NUM_LVL-1:0] clr_mask,
  output logic               pc_load,
  output logic [PC_W-1:0]    new_pc,
  output logic               push_c_valid,
  output logic [PC_W-1:0]    push_c_data,
  output logic               push_d_valid,
  output logic [SR_W-1:0]    push_d_data,
  output logic               pop_c,
  output logic               pop_d
);
  logic do_ret, do_take;

  // a return completes first; the entry waits for the next boundary
  assign do_ret   = insn_boundary & ret_req;
  assign do_take  = insn_boundary & take_valid & ~ret_req;
  assign clr_mask = do_take ? (NUM_LVL'(1) << take_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_load      <= 1'b0;
      new_pc       <= '0;
      push_c_valid <= 1'b0;
      push_c_data  <= '0;
      push_d_valid <= 1'b0;
      push_d_data  <= '0;
      pop_c        <= 1'b0;
      pop_d        <= 1'b0;
    end else begin
      pc_load      <= do_take;
      push_c_valid <= do_take;
      push_d_valid <= do_take;
      pop_c        <= do_ret;
      pop_d        <= do_ret;
      if (do_take) begin
        new_pc      <= PC_W'(take_lvl) << 1;
        push_c_data <= cur_pc;
        push_d_data <= status_reg;
      end
    end
  end

  // R2: vectors are even and inside the vector table
  p_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (new_pc[0] == 1'b0 && new_pc < PC_W'(2 * NUM_LVL)));

  // R3: both stacks are pushed with the PC load
  p_push_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (push_c_valid && push_d_valid));

  // R9: entry and return never share a cycle
  p_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_load && (pop_c || pop_d)));
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int NUM_LVL = trap_pkg::TRAP_LVLS,
  parameter int PC_W    = trap_pkg::TRAP_PC_W,
  parameter int SR_W    = trap_pkg::TRAP_SR_W,
  parameter int GIE_BIT = trap_pkg::TRAP_GIE_BIT,
  parameter int XIE_BIT = trap_pkg::TRAP_XIE_BIT,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_boundary,
  input  logic [NUM_LVL-2:0] set_req,
  input  logic               ext_flag,
  input  logic [SR_W-1:0]    status_reg,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic               ret_req,
  output logic               pc_load,
  output logic [PC_W-1:0]    new_pc,
  output logic               push_c_valid,
  output logic [PC_W-1:0]    push_c_data,
  output logic               push_d_valid,
  output logic [SR_W-1:0]    push_d_data,
  output logic               pop_c,
  output logic               pop_d
);
  logic [NUM_LVL-1:0] pend;
  logic [NUM_LVL-1:0] clr_mask;
  logic               take_valid;
  logic [LVL_W-1:0]   take_lvl;

  trap_pending #(.NUM_LVL(NUM_LVL)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (set_req),
    .ext_flag (ext_flag),
    .xie      (status_reg[XIE_BIT]),
    .clr_mask (clr_mask),
    .pend     (pend)
  );

  trap_pick #(.NUM_LVL(NUM_LVL)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .gie        (status_reg[GIE_BIT]),
    .take_valid (take_valid),
    .take_lvl   (take_lvl)
  );

  trap_launch #(.NUM_LVL(NUM_LVL), .PC_W(PC_W), .SR_W(SR_W)) u_launch (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .ret_req       (ret_req),
    .take_valid    (take_valid),
    .take_lvl      (take_lvl),
    .cur_pc        (cur_pc),
    .status_reg    (status_reg),
    .clr_mask      (clr_mask),
    .pc_load       (pc_load),
    .new_pc        (new_pc),
    .push_c_valid  (push_c_valid),
    .push_c_data   (push_c_data),
    .push_d_valid  (push_d_valid),
    .push_d_data   (push_d_data),
    .pop_c         (pop_c),
    .pop_d         (pop_d)
  );

  // R7: no boundary, no action in the following cycle
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |=> !(pc_load || push_c_valid || push_d_valid || pop_c || pop_d));

  // R9: a return at a boundary suppresses the entry
  p_ret_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_boundary && ret_req) |=> (!pc_load && pop_c && pop_d));

  // R5: an entry taken with global enable off goes to the top vector
  p_top_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !$past(status_reg[GIE_BIT])) |-> (new_pc == PC_W'(2 * (NUM_LVL - 1))));
endmodule

// File: tb/trap_unit_test.sv
`timescale 1ns/1ps
module trap_unit_test;
  localparam logic [15:0] GIE = 16'h0200;
  localparam logic [15:0] XIE = 16'h0800;
  localparam logic [15:0] BASE = 16'h0035;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_boundary = 1'b0;
  logic [6:0]  set_req = '0;
  logic        ext_flag = 1'b0;
  logic [15:0] status_reg = BASE | GIE;
  logic [15:0] cur_pc = 16'h1000;
  logic        ret_req = 1'b0;
  logic        pc_load, push_c_valid, push_d_valid, pop_c, pop_d;
  logic [15:0] new_pc, push_c_data, push_d_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trap_unit uut (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .set_req(set_req),
    .ext_flag(ext_flag), .status_reg(status_reg), .cur_pc(cur_pc), .ret_req(ret_req),
    .pc_load(pc_load), .new_pc(new_pc), .push_c_valid(push_c_valid),
    .push_c_data(push_c_data), .push_d_valid(push_d_valid), .push_d_data(push_d_data),
    .pop_c(pop_c), .pop_d(pop_d)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic raise(input logic [6:0] bits);
    set_req = bits;
    tick();
    set_req = '0;
  endtask

  task automatic ext_pulse();
    ext_flag = 1'b1;
    tick();
    ext_flag = 1'b0;
  endtask

  // one boundary; checks the registered response one cycle later
  task automatic boundary(input logic ret, input logic [6:0] sets, input logic load,
                          input logic [15:0] vec, input string req);
    logic [15:0] pc_s, sr_s;
    cur_pc = cur_pc + 16'h0011;
    pc_s = cur_pc;
    sr_s = status_reg;
    insn_boundary = 1'b1;
    ret_req = ret;
    set_req = sets;
    tick();
    insn_boundary = 1'b0;
    ret_req = 1'b0;
    set_req = '0;
    check({req, " pc_load"}, 32'(pc_load), 32'(load));
    check({req, " pop"}, {30'd0, pop_c, pop_d}, {30'd0, ret, ret});
    if (load) begin
      check({req, " new_pc"}, 32'(new_pc), 32'(vec));
      check({req, " R3 push strobes"}, {30'd0, push_c_valid, push_d_valid}, 32'd3);
      check({req, " R3 push_c_data"}, 32'(push_c_data), 32'(pc_s));
      check({req, " R3 push_d_data"}, 32'(push_d_data), 32'(sr_s));
    end else begin
      check({req, " R7 no push"}, {30'd0, push_c_valid, push_d_valid}, 32'd0);
    end
    tick();
    check({req, " R2 one-cycle pulse"}, {29'd0, pc_load, pop_c, pop_d}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 pc_load", 32'(pc_load), 0);
    check("R1 strobes", {27'd0, push_c_valid, push_d_valid, pop_c, pop_d, 1'b0}, 0);
    check("R1 new_pc", 32'(new_pc), 0);
    status_reg = BASE | GIE;
    boundary(1'b0, '0, 1'b0, 16'h0, "R1 empty after reset");
  endtask

  task automatic t_priority();
    status_reg = BASE | GIE;
    raise(7'b0101100);
    boundary(1'b0, '0, 1'b1, 16'd4, "R2 lowest of 2,3,5");
    boundary(1'b0, '0, 1'b1, 16'd6, "R4 next level 3");
    boundary(1'b0, '0, 1'b1, 16'd10, "R4 next level 5");
    boundary(1'b0, '0, 1'b0, 16'd0, "R4 drained");
  endtask

  task automatic t_gie();
    status_reg = BASE;
    raise(7'b0000010);
    boundary(1'b0, '0, 1'b0, 16'd0, "R5 level 1 masked");
    status_reg = BASE | XIE;
    ext_pulse();
    boundary(1'b0, '0, 1'b1, 16'd14, "R5 level 7 bypasses enable");
    status_reg = BASE | GIE;
    boundary(1'b0, '0, 1'b1, 16'd2, "R5 level 1 after enable");
    boundary(1'b0, '0, 1'b0, 16'd0, "R5 drained");
  endtask

  task automatic t_ext_gate();
    status_reg = BASE | GIE;
    ext_pulse();
    boundary(1'b0, '0, 1'b0, 16'd0, "R6 flag without enable");
    status_reg = BASE | GIE | XIE;
    tick();
    boundary(1'b0, '0, 1'b0, 16'd0, "R6 enable without flag");
    ext_pulse();
    boundary(1'b0, '0, 1'b1, 16'd14, "R6 flag and enable");
    status_reg = BASE | GIE;
  endtask

  task automatic t_no_boundary();
    status_reg = BASE | GIE;
    raise(7'b0100000);
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R7 idle without boundary", 32'(pc_load), 0);
    end
    boundary(1'b0, '0, 1'b1, 16'd10, "R7 level kept until boundary");
  endtask

  task automatic t_merge();
    status_reg = BASE | GIE;
    raise(7'b0010010);
    boundary(1'b0, 7'b0001000, 1'b1, 16'd2, "R8 take 1 with raise 3");
    boundary(1'b0, '0, 1'b1, 16'd6, "R8 merged level 3");
    boundary(1'b0, '0, 1'b1, 16'd8, "R8 level 4");
    raise(7'b0000100);
    boundary(1'b0, 7'b0000100, 1'b1, 16'd4, "R8 take 2 with raise 2");
    boundary(1'b0, '0, 1'b1, 16'd4, "R8 raise wins over clear");
    boundary(1'b0, '0, 1'b0, 16'd0, "R8 drained");
  endtask

  task automatic t_ret();
    status_reg = BASE | GIE;
    raise(7'b0000001);
    boundary(1'b1, '0, 1'b0, 16'd0, "R9 return first");
    boundary(1'b0, '0, 1'b1, 16'd0, "R9 deferred entry level 0");
    boundary(1'b1, '0, 1'b0, 16'd0, "R9 plain return");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_priority();
    t_gie();
    t_ext_gate();
    t_no_boundary();
    t_merge();
    t_ret();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule